// File: doc/BRIEF.md
# Sleep Output Retention Stage

This block sits between the pin-mux output matrix and the pads. Each output pin carries a data bit and an output-enable bit. For every pin, software picks what the pad should do while the chip is asleep. It can pass the live value through unchanged, drive low, drive high, float, or hold the data and enable values seen just before sleep. Each pin has a data retention flop and an enable retention flop, and the chosen sleep values are loaded into them.

The power controller raises a single sleep trigger. On the rising edge of that trigger, every pin with a retaining mode loads its retention flops together and switches to them. A pin then stays retained until software releases it with its own release strobe. Pins that are released return to the live mux values one cycle later. This keeps each pad stable until the peripheral behind it has been set up again.

Top module: `sleep_retention`

## Requirements
- R1: After reset no pin is retained and every pad output equals the live mux data and enable. The stored mode of every pin resets to code 0 (pass-through).
- R2: Each pin stores a 3-bit mode, written from `cfg_mode_i` on a cycle where its `cfg_we_i` bit is high. The codes are 0 pass-through, 1 drive low, 2 drive high, 3 high-Z and 4 keep. Codes 5 to 7 behave as pass-through.
- R3: A rising edge of `sleep_trig_i`, sampled at a clock edge, arms every non-retained pin whose mode is 1 to 4 at that same clock edge. From the next cycle the pin drives its retention flops.
- R4: Drive low gives data 0 and enable 1. Drive high gives data 1 and enable 1. High-Z gives data 0 and enable 0.
- R5: In keep mode, the data and enable captured are the live values present just before the arming clock edge. Later changes on the live inputs do not reach the pad.
- R6: A pin in pass-through mode (including codes 5 to 7) keeps following the live inputs while the trigger is active.
- R7: A high `rel_i` bit releases that pin alone. From the next cycle the pin follows the live inputs, and other pins are not affected.
- R8: While a pin is retained, its pad data and enable stay constant. A new trigger edge and a mode write both leave the pad unchanged.
- R9: When a trigger edge and a release arrive in the same cycle on a pin that is not retained, the trigger edge wins and the pin is armed.
- R10: Holding `sleep_trig_i` high does not arm a pin again after it is released. Only a new rising edge arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| live_out_i | input | NUM_PINS | Output data from the mux |
| live_oe_i | input | NUM_PINS | Output enable from the mux |
| sleep_trig_i | input | 1 | Sleep trigger from the power controller |
| cfg_we_i | input | NUM_PINS | Per-pin mode write strobe |
| cfg_mode_i | input | 3 | Mode value to write |
| rel_i | input | NUM_PINS | Per-pin release strobe |
| pad_out_o | output | NUM_PINS | Data sent to the pad |
| pad_oe_o | output | NUM_PINS | Output enable sent to the pad |

## Verification
The assertions check three rules on every cycle. A pin becomes retained only after a trigger edge. A retained pad holds its data and enable constant. A release without a trigger edge drops retention in the next cycle. An armed drive-low, drive-high or high-Z pin also shows the forced pattern one cycle after arming. The bench scenarios cover the rest. They show the keep snapshot taken across the arming edge, and that a release reaches only its own pin. They also show that the trigger wins over a same-cycle release, that a held trigger does not re-arm, and that codes 5 to 7 act as pass-through.

// File: rtl/sleep_retention_pkg.sv
package sleep_retention_pkg;
  typedef enum logic [2:0] {
    SLP_PASS = 3'd0,
    SLP_LOW  = 3'd1,
    SLP_HIGH = 3'd2,
    SLP_HIZ  = 3'd3,
    SLP_KEEP = 3'd4
  } slp_mode_e;

  typedef struct packed {
    logic dat;
    logic oe;
  } pad_drv_t;
endpackage

// File: rtl/sleep_trig_edge.sv
module sleep_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/sleep_ret_cell.sv
module sleep_ret_cell
  import sleep_retention_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       arm_i,
  input  logic       rel_i,
  input  logic       live_out_i,
  input  logic       live_oe_i,
  output logic       pad_out_o,
  output logic       pad_oe_o
);
  logic [2:0] mode_q;
  logic       active_q;
  pad_drv_t   ret_q, cap;
  logic       retain;

  always_comb begin
    retain = 1'b1;
    cap    = '{dat: 1'b0, oe: 1'b0};
    unique case (mode_q)
      SLP_LOW:  cap = '{dat: 1'b0, oe: 1'b1};
      SLP_HIGH: cap = '{dat: 1'b1, oe: 1'b1};
      SLP_HIZ:  cap = '{dat: 1'b0, oe: 1'b0};
      SLP_KEEP: cap = '{dat: live_out_i, oe: live_oe_i};
      default:  retain = 1'b0; // pass-through and unused codes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= SLP_PASS;
    else if (cfg_we_i) mode_q <= cfg_mode_i;
  end

  // arming beats release on an idle pin; retained pins ignore new edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ret_q    <= '0;
    end else if (arm_i && !active_q && retain) begin
      active_q <= 1'b1;
      ret_q    <= cap;
    end else if (rel_i) begin
      active_q <= 1'b0;
    end
  end

  assign pad_out_o = active_q ? ret_q.dat : live_out_i;
  assign pad_oe_o  = active_q ? ret_q.oe  : live_oe_i;

  p_arm_needs_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(arm_i));

  p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> ($stable(pad_out_o) && $stable(pad_oe_o)));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !arm_i) |=> !active_q);

  p_forced_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !active_q && (mode_q == SLP_HIZ)) |=> (!pad_oe_o && !pad_out_o));

  p_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !active_q && (mode_q == SLP_LOW)) |=> (pad_oe_o && !pad_out_o));

  p_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !active_q && (mode_q == SLP_HIGH)) |=> (pad_oe_o && pad_out_o));
endmodule

// File: rtl/sleep_retention.sv
module sleep_retention #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] live_out_i,
  input  logic [NUM_PINS-1:0] live_oe_i,
  input  logic                sleep_trig_i,
  input  logic [NUM_PINS-1:0] cfg_we_i,
  input  logic [2:0]          cfg_mode_i,
  input  logic [NUM_PINS-1:0] rel_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  logic arm;

  sleep_trig_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(sleep_trig_i),
    .rise_o(arm)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    sleep_ret_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_we_i  (cfg_we_i[g]),
      .cfg_mode_i(cfg_mode_i),
      .arm_i     (arm),
      .rel_i     (rel_i[g]),
      .live_out_i(live_out_i[g]),
      .live_oe_i (live_oe_i[g]),
      .pad_out_o (pad_out_o[g]),
      .pad_oe_o  (pad_oe_o[g])
    );
  end

  p_reset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_out_o == live_out_i && pad_oe_o == live_oe_i));
endmodule

// File: tb/sleep_retention_tb.sv
module sleep_retention_tb;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] live_out_i = '0, live_oe_i = '0, cfg_we_i = '0, rel_i = '0;
  logic         sleep_trig_i = 1'b0;
  logic [2:0]   cfg_mode_i = '0;
  logic [N-1:0] pad_out_o, pad_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sleep_retention #(.NUM_PINS(N)) u_dut (.*);

  // {mode[2:0], live_out, live_oe, exp_out, exp_oe} for pin 0
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd5, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd7, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd4, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(string req, logic [N-1:0] ao, logic [N-1:0] aoe,
                       logic [N-1:0] eo, logic [N-1:0] eoe);
    n_chk++;
    if (ao !== eo || aoe !== eoe) begin
      n_fail++;
      $display("FAIL %s out=%b oe=%b expected out=%b oe=%b", req, ao, aoe, eo, eoe);
    end
  endtask

  task automatic wr_mode(logic [N-1:0] pins, logic [2:0] m);
    cfg_we_i = pins; cfg_mode_i = m;
    @(negedge clk_i); cfg_we_i = '0;
  endtask

  task automatic trig_pulse();
    sleep_trig_i = 1'b1;
    @(negedge clk_i); sleep_trig_i = 1'b0;
  endtask

  task automatic release_pins(logic [N-1:0] pins);
    rel_i = pins;
    @(negedge clk_i); rel_i = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    // R1: reset state, live passes through
    live_out_i = 4'b0110; live_oe_i = 4'b0011;
    #1 check("R1", pad_out_o, pad_oe_o, 4'b0110, 4'b0011);
    rst_ni = 1'b1;
    @(negedge clk_i);
    trig_pulse();
    check("R1", pad_out_o, pad_oe_o, 4'b0110, 4'b0011);

    // table walk on pin 0: R2 R3 R4 R5 R6, then R7 release
    foreach (VEC[i]) begin
      wr_mode(4'b0001, VEC[i][6:4]);
      live_out_i = {3'b000, VEC[i][3]}; live_oe_i = {3'b000, VEC[i][2]};
      @(negedge clk_i);
      trig_pulse();
      check("R2/R4", pad_out_o, pad_oe_o, {3'b000, VEC[i][1]}, {3'b000, VEC[i][0]});
      release_pins(4'b0001);
      live_out_i = {3'b000, ~VEC[i][3]}; live_oe_i = {3'b000, ~VEC[i][2]};
      #1 check("R7", pad_out_o, pad_oe_o, {3'b000, ~VEC[i][3]}, {3'b000, ~VEC[i][2]});
      @(negedge clk_i);
    end

    // R5 + R3: all pins keep, parallel capture
    wr_mode(4'b1111, 3'd4);
    live_out_i = 4'b1010; live_oe_i = 4'b1100;
    @(negedge clk_i);
    trig_pulse();
    live_out_i = 4'b0101; live_oe_i = 4'b0011;
    @(negedge clk_i);
    check("R5", pad_out_o, pad_oe_o, 4'b1010, 4'b1100);

    // R7: release pin 1 only
    release_pins(4'b0010);
    check("R7", pad_out_o, pad_oe_o, 4'b1000, 4'b1110);

    // R8: a new edge leaves retained pins, re-arms released pin 1
    live_out_i = 4'b1111; live_oe_i = 4'b1111;
    @(negedge clk_i);
    trig_pulse();
    check("R8", pad_out_o, pad_oe_o, 4'b1010, 4'b1110);

    // R8: mode write on retained pin 0 has no effect
    wr_mode(4'b0001, 3'd1);
    @(negedge clk_i);
    check("R8", pad_out_o, pad_oe_o, 4'b1010, 4'b1110);

    // R9: release and edge in one cycle on idle pins -> armed
    release_pins(4'b1111);
    live_out_i = 4'b0000; live_oe_i = 4'b0000;
    @(negedge clk_i);
    rel_i = 4'b1111; sleep_trig_i = 1'b1;
    @(negedge clk_i);
    rel_i = '0;
    live_out_i = 4'b1111; live_oe_i = 4'b1111;
    #1 check("R9", pad_out_o, pad_oe_o, 4'b0000, 4'b0001);

    // R10: trigger held high, release -> no re-arm
    release_pins(4'b1111);
    repeat (3) @(negedge clk_i);
    check("R10", pad_out_o, pad_oe_o, 4'b1111, 4'b1111);
    sleep_trig_i = 1'b0;
    @(negedge clk_i);

    // R6: pass-through pins follow live while others retained
    wr_mode(4'b0011, 3'd0);
    wr_mode(4'b1100, 3'd2);
    live_out_i = 4'b0000; live_oe_i = 4'b0000;
    trig_pulse();
    live_out_i = 4'b0001; live_oe_i = 4'b0010;
    #1 check("R6", pad_out_o, pad_oe_o, 4'b1101, 4'b1110);
    @(negedge clk_i);

    // R1: reset clears retention
    rst_ni = 1'b0;
    #1 check("R1", pad_out_o, pad_oe_o, 4'b0001, 4'b0010);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule